// File: doc/BRIEF.md
# Serial Port Register and FIFO Controller

This block is the processor-facing side of a serial port. A simple word-addressed bus reaches six registers: a transmit queue entry point, a receive queue exit point, a control word, a status word, an interrupt level word and a baud setting word. Control bits are driven straight out to an external bit-level serializer and deserializer. These bits set the character length, the parity, the stop bits, the flow-control mode and the two direction enables. The baud word is passed through unchanged for the tick generator.

Transmit bytes leave through a valid/ready pair. Received bytes arrive with their own parity and framing error flags. They are queued and then popped by reads. Error conditions latch and stay set until software raises the clear bit in the control word and then lowers it. One interrupt line combines a receive level condition and a transmit level condition. Each condition has its own enable and its own threshold.

Top module: `sio_csr_top`

## Requirements
- R1: After reset every register reads zero except status, which reads 0x0050_0000 (receive queue empty at bit 20, transmit queue empty at bit 22); irq, tx_valid and every configuration output are low.
- R2: Control bit 12 drives cfg_tx_en and bit 13 drives cfg_rx_en. Bits 21:20 drive cfg_data_len (0 = 8 bits, 1 = 7, 2 = 6, 3 = 5). Bit 19 drives cfg_par_en, bit 18 drives cfg_par_odd, bits 17:16 drive cfg_stop (0 = one, 1 = two) and bit 15 drives cfg_two_wire. Offset 0x08 reads back the whole word.
- R3: Bytes written to offset 0x00 leave on tx_data in write order. tx_valid is high only while control bit 12 is set and the queue holds data, and a byte is consumed on each cycle with tx_valid and tx_ready high.
- R4: The transmit queue holds FIFO_DEPTH (64) bytes. At that level status bit 21 is set. A further write to 0x00 is dropped and sets sticky status bit 18.
- R5: A read of offset 0x04 pops one received byte and returns it zero-extended in bits 7:0. A read while the queue is empty returns zero and removes nothing.
- R6: A byte accepted with its parity flag sets sticky status bit 16, and a byte accepted with its framing flag sets sticky bit 17. Both stay set after the byte is read. A line break is stored as data 0x00 together with bit 17.
- R7: While control bit 24 is high, status bits 16, 17 and 18 read zero and cannot be set. Lowering bit 24 leaves them clear.
- R8: While control bit 22 is high the transmit queue is emptied and writes to it are discarded. While bit 23 is high the receive queue is emptied and incoming bytes are discarded.
- R9: irq rises when control bits 27 and 13 are set and the receive queue count is at or above bits 7:0 of offset 0x10.
- R10: irq rises when control bits 28 and 12 are set and the transmit queue count is below bits 15:8 of offset 0x10. With no condition true, irq is low.
- R11: Status bit 25 follows the tx_busy input, so the transmitter is idle only when bit 22 is set and bit 25 is clear.
- R12: Offset 0x10 keeps bits 15:0 and reads the rest as zero. Offset 0x14 keeps all 32 bits and drives baud_cfg. Writes to 0x04 and 0x0C change nothing.
- R13: Bytes offered on rx_valid while control bit 13 is clear are not queued and set no error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the word register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered, valid the cycle after the read |
| cfg_tx_en | output | 1 | Transmit enable |
| cfg_rx_en | output | 1 | Receive enable |
| cfg_data_len | output | 2 | Character length code |
| cfg_par_en | output | 1 | Parity enable |
| cfg_par_odd | output | 1 | Odd parity select |
| cfg_stop | output | 2 | Stop bit code |
| cfg_two_wire | output | 1 | No hardware flow control |
| baud_cfg | output | DATA_W | Baud setting word |
| tx_data | output | 8 | Byte at the head of the transmit queue |
| tx_valid | output | 1 | tx_data is offered |
| tx_ready | input | 1 | Serializer takes the byte |
| tx_busy | input | 1 | Serializer is still shifting |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | rx_data and flags are valid this cycle |
| rx_par_err | input | 1 | Parity error on this byte |
| rx_frm_err | input | 1 | Framing error on this byte |
| irq | output | 1 | Interrupt request, registered |

## Verification
The hardest state to reach is a full transmit queue followed by one more write. The serializer drains the queue as soon as transmit is enabled, so the bench holds transmit disabled. It then issues sixty-four writes and a sixty-fifth, and drains the queue afterwards to show that the extra byte never entered. A similar problem arises when both soft resets are held while traffic is still offered on both sides. The bench queues bytes in each direction first, so that the flush and the discarding can be seen through status and tx_valid.

// File: rtl/sio_pkg.sv
package sio_pkg;
  // Word register byte offsets
  localparam logic [4:0] OFS_TXQ  = 5'h00;
  localparam logic [4:0] OFS_RXQ  = 5'h04;
  localparam logic [4:0] OFS_CTRL = 5'h08;
  localparam logic [4:0] OFS_STAT = 5'h0C;
  localparam logic [4:0] OFS_LVL  = 5'h10;
  localparam logic [4:0] OFS_BAUD = 5'h14;

  // Control word bit positions
  localparam int C_TWO_WIRE = 15;
  localparam int C_STOP_LO  = 16;
  localparam int C_PAR_ODD  = 18;
  localparam int C_PAR_EN   = 19;
  localparam int C_LEN_LO   = 20;
  localparam int C_TX_EN    = 12;
  localparam int C_RX_EN    = 13;
  localparam int C_TX_RST   = 22;
  localparam int C_RX_RST   = 23;
  localparam int C_ERR_CLR  = 24;
  localparam int C_RX_IE    = 27;
  localparam int C_TX_IE    = 28;

  // Status word bit positions
  localparam int S_PAR_ERR  = 16;
  localparam int S_FRM_ERR  = 17;
  localparam int S_WR_ERR   = 18;
  localparam int S_RX_EMPTY = 20;
  localparam int S_TX_FULL  = 21;
  localparam int S_TX_EMPTY = 22;
  localparam int S_TX_BUSY  = 25;
endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign dout    = mem[rd_ptr];

  // Storage has no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  // R4: a push on a full queue without a pop leaves it full, never wraps
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !clr) |=> full);
  // R5: a pop on an empty queue without a push leaves it empty
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> empty);
endmodule

// File: rtl/sio_irq.sv
module sio_irq #(
  parameter int CW   = 7,
  parameter int LW   = 8,
  localparam int MW  = (CW > LW) ? CW : LW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_on,
  input  logic          tx_on,
  input  logic [CW-1:0] rx_cnt,
  input  logic [CW-1:0] tx_cnt,
  input  logic [LW-1:0] rx_lvl,
  input  logic [LW-1:0] tx_lvl,
  output logic          irq
);
  logic rx_hit, tx_hit;

  assign rx_hit = MW'(rx_cnt) >= MW'(rx_lvl);
  assign tx_hit = MW'(tx_cnt) <  MW'(tx_lvl);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (rx_on && rx_hit) || (tx_on && tx_hit);
  end

  // R9: receive level reached with the condition enabled raises irq next cycle
  assert_rx_level_R9: assert property (@(posedge clk) disable iff (rst)
    (rx_on && rx_hit) |=> irq);
  // R10: with both conditions disabled the line drops
  assert_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (!rx_on && !tx_on) |=> !irq);
endmodule

// File: rtl/sio_csr_top.sv
module sio_csr_top #(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 64,
  parameter int LVL_W      = 8,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cfg_tx_en,
  output logic              cfg_rx_en,
  output logic [1:0]        cfg_data_len,
  output logic              cfg_par_en,
  output logic              cfg_par_odd,
  output logic [1:0]        cfg_stop,
  output logic              cfg_two_wire,
  output logic [DATA_W-1:0] baud_cfg,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic              tx_busy,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  input  logic              rx_par_err,
  input  logic              rx_frm_err,
  output logic              irq
);
  import sio_pkg::*;

  logic [DATA_W-1:0]  ctrl_q, baud_q, status;
  logic [2*LVL_W-1:0] lvl_q;
  logic               err_par, err_frm, err_wr;
  logic               wr, rd, hit_txq, hit_rxq;
  logic               tx_push, tx_pop, tx_clr, tx_full, tx_empty;
  logic               rx_take, rx_pop, rx_clr, rx_full, rx_empty;
  logic [CW-1:0]      tx_cnt, rx_cnt;
  logic [7:0]         rx_head;

  assign wr      = bus_req && bus_we;
  assign rd      = bus_req && !bus_we;
  assign hit_txq = (bus_addr == ADDR_W'(OFS_TXQ));
  assign hit_rxq = (bus_addr == ADDR_W'(OFS_RXQ));

  assign tx_clr  = ctrl_q[C_TX_RST];
  assign rx_clr  = ctrl_q[C_RX_RST];
  assign tx_push = wr && hit_txq;
  assign tx_valid = ctrl_q[C_TX_EN] && !tx_empty;
  assign tx_pop  = tx_valid && tx_ready;
  assign rx_take = rx_valid && ctrl_q[C_RX_EN] && !rx_clr;
  assign rx_pop  = rd && hit_rxq;

  sio_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(tx_clr), .push(tx_push), .din(bus_wdata[7:0]),
    .pop(tx_pop), .dout(tx_data), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  sio_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clr(rx_clr), .push(rx_take), .din(rx_data),
    .pop(rx_pop), .dout(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  sio_irq #(.CW(CW), .LW(LVL_W)) u_irq (
    .clk(clk), .rst(rst),
    .rx_on(ctrl_q[C_RX_IE] && ctrl_q[C_RX_EN]),
    .tx_on(ctrl_q[C_TX_IE] && ctrl_q[C_TX_EN]),
    .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
    .rx_lvl(lvl_q[LVL_W-1:0]), .tx_lvl(lvl_q[2*LVL_W-1:LVL_W]),
    .irq(irq));

  // Writable registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      lvl_q  <= '0;
      baud_q <= '0;
    end else if (wr) begin
      if (bus_addr == ADDR_W'(OFS_CTRL)) ctrl_q <= bus_wdata;
      if (bus_addr == ADDR_W'(OFS_LVL))  lvl_q  <= bus_wdata[2*LVL_W-1:0];
      if (bus_addr == ADDR_W'(OFS_BAUD)) baud_q <= bus_wdata;
    end
  end

  // Sticky error flags; the level-held clear wins over any new event
  always_ff @(posedge clk) begin
    if (rst || ctrl_q[C_ERR_CLR]) begin
      err_par <= 1'b0;
      err_frm <= 1'b0;
      err_wr  <= 1'b0;
    end else begin
      if (rx_take && rx_par_err)            err_par <= 1'b1;
      if (rx_take && rx_frm_err)            err_frm <= 1'b1;
      if (tx_push && tx_full && !tx_clr)    err_wr  <= 1'b1;
    end
  end

  always_comb begin
    status             = '0;
    status[S_PAR_ERR]  = err_par;
    status[S_FRM_ERR]  = err_frm;
    status[S_WR_ERR]   = err_wr;
    status[S_RX_EMPTY] = rx_empty;
    status[S_TX_FULL]  = tx_full;
    status[S_TX_EMPTY] = tx_empty;
    status[S_TX_BUSY]  = tx_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd) begin
      unique case (bus_addr)
        ADDR_W'(OFS_RXQ):  bus_rdata <= rx_empty ? '0 : DATA_W'(rx_head);
        ADDR_W'(OFS_CTRL): bus_rdata <= ctrl_q;
        ADDR_W'(OFS_STAT): bus_rdata <= status;
        ADDR_W'(OFS_LVL):  bus_rdata <= DATA_W'(lvl_q);
        ADDR_W'(OFS_BAUD): bus_rdata <= baud_q;
        default:           bus_rdata <= '0;
      endcase
    end
  end

  assign cfg_tx_en    = ctrl_q[C_TX_EN];
  assign cfg_rx_en    = ctrl_q[C_RX_EN];
  assign cfg_data_len = ctrl_q[C_LEN_LO +: 2];
  assign cfg_par_en   = ctrl_q[C_PAR_EN];
  assign cfg_par_odd  = ctrl_q[C_PAR_ODD];
  assign cfg_stop     = ctrl_q[C_STOP_LO +: 2];
  assign cfg_two_wire = ctrl_q[C_TWO_WIRE];
  assign baud_cfg     = baud_q;

  // R3: nothing is offered while transmit is disabled
  assert_tx_gate_R3: assert property (@(posedge clk) disable iff (rst)
    !cfg_tx_en |-> !tx_valid);
  // R4: a write into a full queue latches the write error
  assert_wr_err_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_push && tx_full && !tx_clr && !ctrl_q[C_ERR_CLR]) |=> err_wr);
  // R7: error flags stay clear while the clear bit is held
  assert_clear_holds_R7: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[C_ERR_CLR] |=> (!err_par && !err_frm && !err_wr));
  // R8: transmit soft reset empties the queue
  assert_txrst_empty_R8: assert property (@(posedge clk) disable iff (rst)
    tx_clr |=> tx_empty);
  // R13: receive disabled means the receive count cannot grow
  assert_rx_gate_R13: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[C_RX_EN] && !rx_pop && !rx_clr) |=> (rx_cnt <= $past(rx_cnt)));
endmodule

// File: tb/tb_sio_csr_top.sv
module tb_sio_csr_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cfg_tx_en, cfg_rx_en, cfg_par_en, cfg_par_odd, cfg_two_wire;
  logic [1:0]  cfg_data_len, cfg_stop;
  logic [31:0] baud_cfg;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0, tx_busy = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0, rx_par_err = 1'b0, rx_frm_err = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  sio_csr_top dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_tx_en(cfg_tx_en),
    .cfg_rx_en(cfg_rx_en), .cfg_data_len(cfg_data_len), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_stop(cfg_stop), .cfg_two_wire(cfg_two_wire),
    .baud_cfg(baud_cfg), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_busy(tx_busy), .rx_data(rx_data), .rx_valid(rx_valid), .rx_par_err(rx_par_err),
    .rx_frm_err(rx_frm_err), .irq(irq));

  typedef struct packed {
    logic        we;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 5'h10, 32'hFFFF_1234, 32'h0},          // R12 level word
    '{1'b0, 5'h10, 32'h0,         32'h0000_1234},  // R12 upper bits dropped
    '{1'b1, 5'h14, 32'h0001_ABCD, 32'h0},          // R12 baud word
    '{1'b0, 5'h14, 32'h0,         32'h0001_ABCD},
    '{1'b1, 5'h0C, 32'hFFFF_FFFF, 32'h0},          // R12 status not writable
    '{1'b0, 5'h0C, 32'h0,         32'h0050_0000},
    '{1'b1, 5'h04, 32'h0000_00AA, 32'h0},          // R12 receive port not writable
    '{1'b0, 5'h04, 32'h0,         32'h0},          // R5 empty read
    '{1'b1, 5'h08, 32'h002D_B000, 32'h0},          // R2 control readback
    '{1'b0, 5'h08, 32'h0,         32'h002D_B000},
    '{1'b1, 5'h10, 32'h0,         32'h0},
    '{1'b0, 5'h10, 32'h0,         32'h0},
    '{1'b1, 5'h08, 32'h0,         32'h0},
    '{1'b0, 5'h08, 32'h0,         32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_req = 1'b0;
  endtask

  task automatic rx_put(input logic [7:0] d, input logic pe, input logic fe);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_par_err = pe; rx_frm_err = fe;
    @(negedge clk);
    rx_valid = 1'b0; rx_par_err = 1'b0; rx_frm_err = 1'b0;
  endtask

  task automatic tx_take(output logic v, output logic [7:0] d);
    @(negedge clk);
    v = tx_valid; d = tx_data; tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic [31:0] r;
    logic        v;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
    chk("R1 cfg outputs", {22'b0, cfg_tx_en, cfg_rx_en, cfg_data_len, cfg_par_en,
        cfg_par_odd, cfg_stop, cfg_two_wire, 1'b0}, 32'h0);
    rd(5'h0C, r); chk("R1 status", r, 32'h0050_0000);
    rd(5'h08, r); chk("R1 control", r, 32'h0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) wr(VECS[i].addr, VECS[i].data);
      else begin
        rd(VECS[i].addr, r);
        chk($sformatf("vector %0d (R2/R5/R12)", i), r, VECS[i].exp);
      end
    end

    // R2 field outputs
    wr(5'h08, 32'h002D_B000);
    chk("R2 fields", {22'b0, cfg_tx_en, cfg_rx_en, cfg_data_len, cfg_par_en,
        cfg_par_odd, cfg_stop, cfg_two_wire, 1'b0}, {22'b0, 10'b11_10_1_1_01_1_0});
    wr(5'h14, 32'h0000_0067);
    chk("R12 baud_cfg", baud_cfg, 32'h0000_0067);

    // R3 order and gating
    wr(5'h08, 32'h0);
    wr(5'h00, 32'hA1); wr(5'h00, 32'hB2); wr(5'h00, 32'hC3);
    idle(2);
    chk("R3 no offer while disabled", {31'b0, tx_valid}, 32'h0);
    wr(5'h08, 32'h0000_3000);
    tx_take(v, b); chk("R3 byte 1", {23'b0, v, b}, {23'b0, 1'b1, 8'hA1});
    tx_take(v, b); chk("R3 byte 2", {23'b0, v, b}, {23'b0, 1'b1, 8'hB2});
    tx_take(v, b); chk("R3 byte 3", {23'b0, v, b}, {23'b0, 1'b1, 8'hC3});
    chk("R3 drained", {31'b0, tx_valid}, 32'h0);

    // R11 busy reflection
    tx_busy = 1'b1;
    rd(5'h0C, r); chk("R11 busy while empty", r, 32'h0250_0000);
    tx_busy = 1'b0;
    rd(5'h0C, r); chk("R11 idle", r, 32'h0050_0000);

    // R4 fill to depth and overflow
    wr(5'h08, 32'h0000_2000);
    for (int i = 0; i < 64; i++) wr(5'h00, 32'(i));
    rd(5'h0C, r); chk("R4 full", r, 32'h0030_0000);
    wr(5'h00, 32'hEE);
    rd(5'h0C, r); chk("R4 write error", r, 32'h0034_0000);
    // R7 clear held then released
    wr(5'h08, 32'h0100_2000);
    rd(5'h0C, r); chk("R7 cleared while held", r, 32'h0030_0000);
    wr(5'h08, 32'h0000_2000);
    rd(5'h0C, r); chk("R7 stays clear", r, 32'h0030_0000);
    wr(5'h08, 32'h0000_3000);
    begin
      int bad = 0;
      for (int i = 0; i < 64; i++) begin
        tx_take(v, b);
        if (!v || b != 8'(i)) bad++;
      end
      chk("R4 drained contents", 32'(bad), 32'h0);
    end
    chk("R4 extra byte absent", {31'b0, tx_valid}, 32'h0);

    // R6 sticky receive errors and break
    rx_put(8'h5A, 1'b1, 1'b0);
    rx_put(8'h00, 1'b0, 1'b1);
    rx_put(8'h33, 1'b0, 1'b0);
    rd(5'h0C, r); chk("R6 flags set", r, 32'h0043_0000);
    rd(5'h04, r); chk("R5 pop 1", r, 32'h5A);
    rd(5'h04, r); chk("R6 break byte", r, 32'h00);
    rd(5'h04, r); chk("R5 pop 3", r, 32'h33);
    rd(5'h04, r); chk("R5 empty read", r, 32'h0);
    rd(5'h0C, r); chk("R6 flags persist", r, 32'h0053_0000);
    wr(5'h08, 32'h0100_3000);
    wr(5'h08, 32'h0000_3000);
    rd(5'h0C, r); chk("R7 pulse clears", r, 32'h0050_0000);

    // R13 receive disabled
    wr(5'h08, 32'h0000_1000);
    rx_put(8'h77, 1'b1, 1'b1);
    rd(5'h0C, r); chk("R13 ignored", r, 32'h0050_0000);

    // R8 soft resets
    wr(5'h08, 32'h0000_3000);
    wr(5'h00, 32'h11); wr(5'h00, 32'h22);
    rx_put(8'h44, 1'b0, 1'b0);
    wr(5'h08, 32'h00C0_3000);
    wr(5'h00, 32'h99);
    rx_put(8'h55, 1'b0, 1'b0);
    wr(5'h08, 32'h0000_3000);
    rd(5'h0C, r); chk("R8 both flushed", r, 32'h0050_0000);
    chk("R8 tx_valid low", {31'b0, tx_valid}, 32'h0);
    rd(5'h04, r); chk("R8 rx discarded", r, 32'h0);

    // R9 receive level interrupt
    wr(5'h10, 32'h0000_0002);
    wr(5'h08, 32'h0800_2000);
    idle(3); chk("R9 below level", {31'b0, irq}, 32'h0);
    rx_put(8'h01, 1'b0, 1'b0);
    idle(3); chk("R9 one short", {31'b0, irq}, 32'h0);
    rx_put(8'h02, 1'b0, 1'b0);
    idle(3); chk("R9 at level", {31'b0, irq}, 32'h1);
    rd(5'h04, r);
    idle(3); chk("R9 dropped after pop", {31'b0, irq}, 32'h0);
    rd(5'h04, r);

    // R10 transmit level interrupt
    wr(5'h10, 32'h0000_0200);
    wr(5'h08, 32'h1000_1000);
    idle(3); chk("R10 empty below level", {31'b0, irq}, 32'h1);
    wr(5'h00, 32'h5);
    idle(3); chk("R10 one below level", {31'b0, irq}, 32'h1);
    wr(5'h00, 32'h6);
    idle(3); chk("R10 at level", {31'b0, irq}, 32'h0);
    wr(5'h08, 32'h1040_1000);
    idle(3); chk("R10 after flush", {31'b0, irq}, 32'h1);
    wr(5'h08, 32'h0);
    idle(3); chk("R10 disabled", {31'b0, irq}, 32'h0);

    done = 1'b1;
    summary();
  end
endmodule